// File: doc/BRIEF.md
# Boot Mode and Program Fetch Decoder

This block holds the processor's three-bit operating mode. It loads the mode from dedicated strap pins on the first clock after reset is released. After that the strap pins have no effect, and only a register write port or the end of a bootstrap changes the mode.

From the held mode the block derives four things:
- whether internal program RAM is enabled;
- which external port, A or B, serves external fetches;
- whether a bootstrap is requested, and from which source;
- a one-cycle start pulse that carries the address where execution begins.

Every program fetch address is steered to exactly one target: internal RAM, external port A or external port B.

A bootstrap engine drives `boot_done` for one cycle when it has loaded internal RAM. If a bootstrap mode is active at that moment, the block does three things:
- it drops to the matching RAM-enabled mode;
- it keeps the port bit;
- it issues a start pulse at address zero.

The data movers, the bus interfaces and the core are outside this block.

Top module: `boot_mode_ctrl`

## Requirements
- R1: The mode loads from `mode_pins` on the first rising clock edge with `rst_n` high. Later changes on `mode_pins` never change `mode`. A write request in that same capture cycle is ignored.
- R2: After capture, `mode_wr_en` high loads `mode_wr_data` into `mode` at the next edge. The exception is a cycle in which R6 applies.
- R3: Whenever the mode is loaded, `port_b_sel` equals mode bit 0. The value 0 means port A and 1 means port B.
- R4: Modes 0 and 1 set `pram_en`. Modes 2 and 3 clear it. Modes 4 through 7 also clear it.
- R5: The start pulse at reset exit depends on the captured mode. For modes 0 and 1 it carries 0xFFFFFFFE. For modes 2 and 3 it carries 0x00000000. In both cases `start_pulse` is high for exactly the one cycle after the capture edge. Modes 4 through 7 issue no pulse at reset exit.
- R6: Modes 4 through 7 assert `boot_req`. Modes 4 and 5 clear `boot_src_host` and drive `boot_base` to 0xFFFF0000 (byte-wide memory on data bits 7..0). Modes 6 and 7 set `boot_src_host` and drive `boot_base` to 0.
- R7: `boot_done` in modes 4 through 7 sets `mode` to {2'b00, mode[0]} at the next edge. It also produces a one-cycle `start_pulse` with `start_addr` equal to 0. This takes priority over a write in the same cycle.
- R8: `boot_done` in modes 0 through 3 has no effect on `mode` or `start_pulse`.
- R9: A fetch is routed as follows, with the mode loaded and `fetch_valid` high:
  - it goes to `route_int` when `pram_en` is set and `fetch_addr` is at most PRAM_WORDS-1;
  - otherwise it goes to `route_ext_b` when bit 0 is 1, and to `route_ext_a` when bit 0 is 0.
  
  Exactly one route is high. With `fetch_valid` low, no route is high.
- R10: During reset, and before the capture edge, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 3 | Strap pins, sampled once at reset exit |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 3 | Mode register write value |
| boot_done | input | 1 | Bootstrap-complete pulse |
| fetch_valid | input | 1 | Program fetch request |
| fetch_addr | input | ADDR_W | Program fetch address |
| mode | output | 3 | Current operating mode |
| pram_en | output | 1 | Internal program RAM enabled |
| port_b_sel | output | 1 | External port select, 1 = B |
| boot_req | output | 1 | Bootstrap requested |
| boot_src_host | output | 1 | Bootstrap source, 1 = host interface |
| boot_base | output | ADDR_W | Byte-wide bootstrap start address |
| start_pulse | output | 1 | One-cycle execution start |
| start_addr | output | ADDR_W | Start address, valid with start_pulse |
| route_int | output | 1 | Fetch goes to internal RAM |
| route_ext_a | output | 1 | Fetch goes to external port A |
| route_ext_b | output | 1 | Fetch goes to external port B |

## Verification
A corrupt mode register appears on `mode` and on the decoded enables in the same cycle it is written. A wrong RAM enable or port bit misroutes the very next valid fetch. The risky cases are fetches at PRAM_WORDS-1 and PRAM_WORDS. A mishandled capture or bootstrap exit shows as a missing, doubled or wrongly addressed start pulse, exactly one cycle after the causing edge.

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int PRAM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              mode_wr_en,
  input  logic [2:0]        mode_wr_data,
  input  logic              boot_done,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [2:0]        mode,
  output logic              pram_en,
  output logic              port_b_sel,
  output logic              boot_req,
  output logic              boot_src_host,
  output logic [ADDR_W-1:0] boot_base,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr,
  output logic              route_int,
  output logic              route_ext_a,
  output logic              route_ext_b
);
  localparam logic [ADDR_W-1:0] PRAM_TOP  = ADDR_W'(PRAM_WORDS - 1);
  localparam logic [ADDR_W-1:0] VEC_HIGH  = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BYTE_BASE = {{(ADDR_W-16){1'b1}}, 16'h0000};

  logic              started_q;
  logic [2:0]        mode_q;
  logic              start_q;
  logic [ADDR_W-1:0] start_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q    <= 1'b0;
      mode_q       <= 3'd0;
      start_q      <= 1'b0;
      start_addr_q <= '0;
    end else begin
      start_q      <= 1'b0;
      start_addr_q <= '0;
      if (!started_q) begin
        started_q <= 1'b1;
        mode_q    <= mode_pins;
        if (!mode_pins[2]) begin
          start_q      <= 1'b1;
          start_addr_q <= mode_pins[1] ? '0 : VEC_HIGH;
        end
      end else if (boot_done && mode_q[2]) begin
        mode_q  <= {2'b00, mode_q[0]};
        start_q <= 1'b1;
      end else if (mode_wr_en) begin
        mode_q <= mode_wr_data;
      end
    end
  end

  logic in_range;
  assign in_range = fetch_addr <= PRAM_TOP;

  assign mode          = mode_q;
  assign pram_en       = started_q && (mode_q[2:1] == 2'b00);
  assign port_b_sel    = started_q && mode_q[0];
  assign boot_req      = started_q && mode_q[2];
  assign boot_src_host = boot_req && mode_q[1];
  assign boot_base     = (boot_req && !mode_q[1]) ? BYTE_BASE : '0;
  assign start_pulse   = start_q;
  assign start_addr    = start_addr_q;
  assign route_int     = fetch_valid && pram_en && in_range;
  assign route_ext_a   = fetch_valid && started_q && !route_int && !mode_q[0];
  assign route_ext_b   = fetch_valid && started_q && !route_int && mode_q[0];
endmodule

module boot_mode_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              started,
  input logic [2:0]        mode,
  input logic              mode_wr_en,
  input logic [2:0]        mode_wr_data,
  input logic              boot_done,
  input logic              fetch_valid,
  input logic              pram_en,
  input logic              port_b_sel,
  input logic              boot_req,
  input logic              start_pulse,
  input logic [ADDR_W-1:0] start_addr,
  input logic              route_int,
  input logic              route_ext_a,
  input logic              route_ext_b
);
  assert_pins_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started) && !$past(mode_wr_en) && !$past(boot_done)) |-> $stable(mode));

  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode_wr_en && !(boot_done && mode[2])) |=> (mode == $past(mode_wr_data)));

  assert_port_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    route_ext_b |-> port_b_sel);

  assert_pram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pram_en |-> (started && mode[2:1] == 2'b00));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_no_boot_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !boot_req);

  assert_boot_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode[2] && boot_done) |=>
      (mode == {2'b00, $past(mode[0])} && start_pulse && start_addr == '0));

  assert_done_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !mode[2] && boot_done && !mode_wr_en) |=> ($stable(mode) && !start_pulse));

  assert_route_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_int, route_ext_a, route_ext_b}));

  assert_route_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && started) |-> ($countones({route_int, route_ext_a, route_ext_b}) == 1));

  assert_safe_R10: assert property (@(posedge clk)
    !started |-> (!boot_req && !pram_en && !start_pulse && !route_int && !route_ext_a && !route_ext_b));
endmodule

bind boot_mode_ctrl boot_mode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .started(started_q), .mode(mode),
  .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .boot_done(boot_done),
  .fetch_valid(fetch_valid), .pram_en(pram_en), .port_b_sel(port_b_sel),
  .boot_req(boot_req), .start_pulse(start_pulse), .start_addr(start_addr),
  .route_int(route_int), .route_ext_a(route_ext_a), .route_ext_b(route_ext_b)
);

// File: tb/boot_mode_ctrl_bench.sv
module boot_mode_ctrl_bench;
  localparam int AW = 32;
  localparam int PW = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode_pins = 3'd0;
  logic          mode_wr_en = 1'b0;
  logic [2:0]    mode_wr_data = 3'd0;
  logic          boot_done = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [2:0]    mode;
  logic          pram_en, port_b_sel, boot_req, boot_src_host, start_pulse;
  logic [AW-1:0] boot_base, start_addr;
  logic          route_int, route_ext_a, route_ext_b;

  boot_mode_ctrl #(.ADDR_W(AW), .PRAM_WORDS(PW)) u_boot_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .mode_wr_en(mode_wr_en),
    .mode_wr_data(mode_wr_data), .boot_done(boot_done), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .mode(mode), .pram_en(pram_en), .port_b_sel(port_b_sel),
    .boot_req(boot_req), .boot_src_host(boot_src_host), .boot_base(boot_base),
    .start_pulse(start_pulse), .start_addr(start_addr), .route_int(route_int),
    .route_ext_a(route_ext_a), .route_ext_b(route_ext_b)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  logic          m_started = 1'b0;
  logic [2:0]    m_mode = 3'd0;
  logic          m_sp = 1'b0;
  logic [AW-1:0] m_sa = '0;

  function automatic logic [AW-1:0] exp_vec(input logic [2:0] m);
    return m[1] ? 32'h0000_0000 : 32'hFFFF_FFFE;
  endfunction

  function automatic logic [2:0] exp_route(input logic st, input logic [2:0] m,
                                           input logic v, input logic [AW-1:0] a);
    if (!st || !v) return 3'b000;
    if (m[2:1] == 2'b00 && a < PW) return 3'b100;
    return m[0] ? 3'b001 : 3'b010;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic [2:0] r;
    r = exp_route(m_started, m_mode, fetch_valid, fetch_addr);
    chk(mode == m_mode, "R1/R2/R7 mode", AW'(mode), AW'(m_mode));
    chk(port_b_sel == (m_started && m_mode[0]), "R3 port", AW'(port_b_sel), AW'(m_started && m_mode[0]));
    chk(pram_en == (m_started && m_mode[2:1] == 2'b00), "R4 pram_en", AW'(pram_en), AW'(m_started && m_mode[2:1] == 2'b00));
    chk(start_pulse == m_sp, "R5 start_pulse", AW'(start_pulse), AW'(m_sp));
    chk(start_addr == m_sa, "R5 start_addr", start_addr, m_sa);
    chk(boot_req == (m_started && m_mode[2]), "R6 boot_req", AW'(boot_req), AW'(m_started && m_mode[2]));
    chk(boot_src_host == (m_started && m_mode[2] && m_mode[1]), "R6 src", AW'(boot_src_host), AW'(m_started && m_mode[2] && m_mode[1]));
    chk(boot_base == ((m_started && m_mode[2:1] == 2'b10) ? 32'hFFFF_0000 : 32'h0), "R6 base",
        boot_base, (m_started && m_mode[2:1] == 2'b10) ? 32'hFFFF_0000 : 32'h0);
    chk({route_int, route_ext_a, route_ext_b} == r, "R9 route", AW'({route_int, route_ext_a, route_ext_b}), AW'(r));
  endtask

  task automatic tick();
    logic          ns, nsp;
    logic [2:0]    nm;
    logic [AW-1:0] nsa;
    ns = m_started; nm = m_mode; nsp = 1'b0; nsa = '0;
    if (!rst_n) begin
      ns = 1'b0; nm = 3'd0;
    end else if (!m_started) begin
      ns = 1'b1; nm = mode_pins;
      if (!mode_pins[2]) begin nsp = 1'b1; nsa = exp_vec(mode_pins); end
    end else if (boot_done && m_mode[2]) begin
      nm = {2'b00, m_mode[0]}; nsp = 1'b1;
    end else if (mode_wr_en) begin
      nm = mode_wr_data;
    end
    @(posedge clk);
    #1;
    m_started = ns; m_mode = nm; m_sp = nsp; m_sa = nsa;
    check_all();
  endtask

  task automatic idle();
    mode_wr_en = 1'b0; boot_done = 1'b0; fetch_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] pins);
    idle();
    #1 rst_n = 1'b0;
    mode_pins = pins;
    m_started = 1'b0; m_mode = 3'd0; m_sp = 1'b0; m_sa = '0;
    #1;
    check_all();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic fetch_at(input logic [AW-1:0] a);
    fetch_valid = 1'b1; fetch_addr = a;
    tick();
  endtask

  logic done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    #1;
    check_all();
    for (int m = 0; m < 8; m++) begin
      do_reset(3'(m));
      mode_wr_en = 1'b1; mode_wr_data = 3'(~m);
      tick();
      idle();
      mode_pins = 3'(m + 3);
      tick();
      fetch_at(AW'(PW - 1));
      fetch_at(AW'(PW));
      fetch_at(32'hFFFF_FFFF);
      fetch_at(32'h0);
      idle();
      boot_done = 1'b1;
      mode_wr_en = 1'b1; mode_wr_data = 3'd2;
      tick();
      idle();
      tick();
      fetch_at(32'h10);
    end
    do_reset(3'd5);
    tick();
    idle();
    boot_done = 1'b1;
    tick();
    idle();
    boot_done = 1'b1;
    tick();
    idle();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        do_reset(3'($urandom_range(0, 7)));
      end
      mode_pins    = 3'($urandom_range(0, 7));
      mode_wr_en   = ($urandom_range(0, 15) == 0);
      mode_wr_data = 3'($urandom_range(0, 7));
      boot_done    = ($urandom_range(0, 7) == 0);
      fetch_valid  = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 3))
        0:       fetch_addr = AW'($urandom_range(PW - 2, PW + 1));
        1:       fetch_addr = AW'($urandom_range(0, PW - 1));
        default: fetch_addr = $urandom;
      endcase
      tick();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule